// File: doc/BRIEF.md
# Strap-Sampled Mode and Suspend Pin Controller

This block owns one bidirectional pad that does two jobs in sequence. Right after reset the pad is left undriven so that an external pull resistor can set its level; the block samples that level once, at a fixed count of clock cycles after reset release, and latches it as the power-switching mode: high means all ports are switched as one group (gang), low means each port is switched on its own (individual). The latched mode is held until the next reset.

Later, at a second fixed count, the block turns the pad into an output and uses it as a suspend indicator. The driven level depends on the latched mode: a gang-strapped board sees 0 in normal operation and 1 in global suspend, an individual-strapped board sees the opposite. The suspend flag is passed through a synchronizer before it reaches the pad. Both delays are parameters counted on the 12 MHz timebase, so a simulation can shorten them.

Top module: `strap_suspend_pin`

## Requirements
- R1: While reset is asserted, pad_oe is 0, pad_out is 0 and gang_mode is 0.
- R2: The pad level is sampled on clock edge number STRAP_CYCLES after reset release (edge 1 being the first rising edge with reset released); gang_mode reads 0 before that edge and the sampled level (1 = gang, 0 = individual) after it.
- R3: Changes of pad_in after the sampling edge have no effect on gang_mode.
- R4: pad_oe rises after clock edge number OUTPUT_CYCLES after reset release and stays 1 until the next reset.
- R5: pad_out is 0 whenever pad_oe is 0.
- R6: With gang_mode 1 and pad_oe 1, pad_out is 0 when not suspended and 1 when suspended.
- R7: With gang_mode 0 and pad_oe 1, pad_out is 1 when not suspended and 0 when suspended.
- R8: A level of global_suspend present before edge k is reflected on pad_out after edge k+2 and not earlier; the synchronizer starts at 0 (not suspended) after reset.
- R9: On the edge where pad_oe rises, pad_out already shows the synchronized suspend level of that cycle, with no extra cycle of default level.
- R10: A new reset clears the latched mode and a new sample is taken after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Level seen at the pad |
| global_suspend | input | 1 | Global suspend flag, asynchronous |
| pad_out | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad output enable, 1 = drive |
| gang_mode | output | 1 | Latched mode, 1 = gang, 0 = individual |

## Verification
The interesting coincidence is a suspend transition that reaches the end of the synchronizer in the same cycle that the output enable switches on, so the first driven value has to be the new suspend level and not the old one or a default. Random sessions toggle the suspend flag at arbitrary cycles, and directed sessions flip it exactly two edges before the switch for both strap values. Every cycle the bench compares pad_out against a model that delays its own record of the applied suspend levels by two edges and applies the mode polarity.

// File: rtl/strap_pin_pkg.sv
package strap_pin_pkg;

  // Level driven on the pad once it is an output.
  // Gang strap: suspended -> 1, running -> 0. Individual strap: the reverse.
  function automatic logic indicator_level(input logic gang, input logic suspended);
    return suspended ? gang : ~gang;
  endfunction

endpackage

// File: rtl/strap_phase_timer.sv
module strap_phase_timer #(
  parameter int unsigned STRAP_CYCLES  = 120,
  parameter int unsigned OUTPUT_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_now,
  output logic drive_now
);
  localparam int unsigned CNT_W = $clog2(OUTPUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(STRAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRIVE_AT  = CNT_W'(OUTPUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(OUTPUT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sample_now = (cnt_q == SAMPLE_AT);
  assign drive_now  = (cnt_q == DRIVE_AT);

  // Sampling must precede the switch to output (R2, R4).
  initial begin
    assert_order_R2 : assert (STRAP_CYCLES >= 1 && STRAP_CYCLES < OUTPUT_CYCLES);
  end

endmodule

// File: rtl/suspend_sync.sv
module suspend_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pin_drive.sv
module pin_drive
  import strap_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic sample_now,
  input  logic drive_now,
  input  logic suspended,
  output logic gang_mode,
  output logic strap_done,
  output logic pad_out,
  output logic pad_oe
);
  logic gang_q, done_q, oe_q, out_q;
  logic oe_next;

  assign oe_next = oe_q | drive_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gang_q <= 1'b0;
      done_q <= 1'b0;
    end else if (sample_now && !done_q) begin
      gang_q <= pad_in;
      done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      oe_q  <= oe_next;
      out_q <= oe_next ? indicator_level(gang_q, suspended) : 1'b0;
    end
  end

  assign gang_mode  = gang_q;
  assign strap_done = done_q;
  assign pad_out    = out_q;
  assign pad_oe     = oe_q;

  assert_mode_held_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> ($stable(gang_q) && done_q));

  assert_oe_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |=> oe_q);

  assert_quiet_when_input_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !out_q);

  assert_sample_before_drive_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    drive_now |-> done_q);

endmodule

// File: rtl/strap_suspend_pin.sv
module strap_suspend_pin #(
  parameter int unsigned STRAP_CYCLES  = 120,
  parameter int unsigned OUTPUT_CYCLES = 600000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic global_suspend,
  output logic pad_out,
  output logic pad_oe,
  output logic gang_mode
);
  logic sample_now, drive_now, suspended, strap_done;

  strap_phase_timer #(
    .STRAP_CYCLES (STRAP_CYCLES),
    .OUTPUT_CYCLES(OUTPUT_CYCLES)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_now(sample_now),
    .drive_now (drive_now)
  );

  suspend_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(global_suspend),
    .sync_out(suspended)
  );

  pin_drive drive_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .sample_now(sample_now),
    .drive_now (drive_now),
    .suspended (suspended),
    .gang_mode (gang_mode),
    .strap_done(strap_done),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  // The mode cannot change while the pad is driven (R3, R6, R7).
  assert_mode_frozen_when_driving_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (strap_done && $stable(gang_mode)));

  // Output may only move when the synchronized suspend level differs from the
  // driven indicator polarity it implies (R8).
  assert_no_spurious_toggle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $stable(suspended)) |=> $stable(pad_out));

endmodule

// File: tb/strap_suspend_pin_tb.sv
module strap_suspend_pin_tb_top;
  localparam int unsigned STRAP_N = 8;
  localparam int unsigned OUT_N   = 40;
  localparam int unsigned SESSION = OUT_N + 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_in = 1'b0;
  logic global_suspend = 1'b0;
  logic pad_out, pad_oe, gang_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strap_suspend_pin #(
    .STRAP_CYCLES (STRAP_N),
    .OUTPUT_CYCLES(OUT_N),
    .SYNC_STAGES  (2)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pad_in        (pad_in),
    .global_suspend(global_suspend),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .gang_mode     (gang_mode)
  );

  // Bench view of the pad level: gang sits at 1 only while suspended,
  // individual sits at 1 only while running.
  function automatic logic want_level(input logic gang, input logic susp);
    if (gang) return susp;
    return !susp;
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  logic hist [0:SESSION];

  // One reset-to-drive session. flip_at > 0 forces a suspend change before that edge.
  task automatic run_session(input int idx, input logic strap, input int flip_at);
    logic s;
    logic exp_out;
    string tag;
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = $urandom_range(0, 1);
    global_suspend = $urandom_range(0, 1);
    repeat (2) @(negedge clk);
    check("R1", "oe in reset", pad_oe, 1'b0);
    check("R1", "out in reset", pad_out, 1'b0);
    check("R1", "mode in reset", gang_mode, 1'b0);
    hist[0] = 1'b0;
    s = $urandom_range(0, 1);
    rst_n = 1'b1;
    for (int k = 1; k <= SESSION; k++) begin
      pad_in = (k <= STRAP_N) ? strap : logic'($urandom_range(0, 1));
      if (flip_at > 0) begin
        if (k == flip_at) s = !s;
      end else if ($urandom_range(0, 5) == 0) begin
        s = !s;
      end
      global_suspend = s;
      hist[k] = s;
      @(posedge clk);
      @(negedge clk);
      // mode
      if (k < STRAP_N) check("R2", "mode before sample", gang_mode, 1'b0);
      else if (k == STRAP_N) check(idx > 0 ? "R10" : "R2", "mode at sample", gang_mode, strap);
      else check("R3", "mode held", gang_mode, strap);
      // output enable
      check("R4", "oe", pad_oe, k >= OUT_N);
      // pad value
      if (k < OUT_N) begin
        check("R5", "out while input", pad_out, 1'b0);
      end else begin
        exp_out = want_level(strap, (k >= 3) ? hist[k-2] : 1'b0);
        if (k == OUT_N) tag = "R9";
        else if (k >= 3 && hist[k-2] != hist[k-3]) tag = "R8";
        else if (k >= 3 && hist[k-1] != hist[k-2]) tag = "R8";
        else tag = strap ? "R6" : "R7";
        check(tag, "pad level", pad_out, exp_out);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    // directed: suspend change lands on the switch edge, both straps
    run_session(0, 1'b1, OUT_N - 2);
    run_session(1, 1'b0, OUT_N - 2);
    // directed: change lands one edge before/after the switch
    run_session(2, 1'b1, OUT_N - 3);
    run_session(3, 1'b0, OUT_N - 1);
    for (int i = 4; i < 30; i++) begin
      run_session(i, logic'($urandom_range(0, 1)), 0);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule